// File: doc/BRIEF.md
# Interleaved Quadrature Oscillator with Receive Mixer

This block is a numerically controlled oscillator that produces cosine and sine samples on one shared output path, one per clock, alternating. A single quarter-wave-free sine table of 1024 signed 18-bit entries serves both components. The cosine sample of each pair is read with a quarter-turn added to the phase. Between adjacent table entries the value is refined by first-order interpolation. The interpolation weight is the 18 phase bits just below the table index. The table contents are computed when the design is elaborated, so no load port exists.

A 32-bit phase accumulator advances by the tuning word once per cosine/sine pair. At an 80 MHz pair rate this gives a step of about 0.02 Hz. The tuning word sits in a register written through a one-cycle strobe. A new word changes the step size without clearing the phase. A two-state sequencer sets the slot. State SLOT_COS always moves to SLOT_SIN, and on that move the quarter-turn offset is applied. State SLOT_SIN always moves to SLOT_COS, and on that move the accumulator advances. Reset enters SLOT_COS.

A receive mixer follows the oscillator. It multiplies one real ADC sample by the cosine sample and then by the sine sample, which yields baseband I followed by Q on one output.

Top module: `dds_iq_nco`

## Requirements
- R1: While reset is low, `nco_out`, `nco_valid`, `bb_out` and `bb_valid` are all 0. After reset `nco_valid` rises once and then stays high.
- R2: `nco_is_sin` is 0 for a cosine sample and 1 for a sine sample. The first valid sample after reset is cosine, and the flag toggles on every following cycle.
- R3: The 32-bit accumulator starts at 0 and advances by the tuning word only when the sequencer leaves SLOT_SIN, so it advances once per cosine/sine pair.
- R4: With P the accumulator value of a slot and A = 131071, a cosine sample is within 2 LSB of A·cos(2πP/2^32) and a sine sample is within 2 LSB of A·sin(2πP/2^32). No sample ever exceeds A in magnitude.
- R5: A word on `freq_data` with `freq_wr` high is stored at that clock edge and is first added at the next accumulator advance after the store. The phase stays continuous across the change, and without `freq_wr` the stored word is kept.
- R6: The table index wraps modulo 1024. At index 1023 the interpolation reaches toward entry 0: phase 0xFFE00000 gives a sine sample of exactly -402.
- R7: A slot's sample appears on `nco_out` exactly 8 clock cycles after the clock edge that set that slot's accumulator value and sequencer state.
- R8: One cycle after each valid oscillator sample, `bb_out` equals a signed ADC value times that sample, and `bb_is_q` equals the sample's `nco_is_sin`. The ADC value is the `adc_data` present in the cosine cycle, and the same value is reused for the sine sample that follows. `bb_valid` follows `nco_valid` one cycle later.
- R9: With a tuning word of 0 after reset, every cosine sample is exactly 131071 and every sine sample is exactly 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one output sample per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| freq_wr | input | 1 | Strobe that stores `freq_data` as the tuning word |
| freq_data | input | 32 | Tuning word (phase step per pair) |
| adc_data | input | 14 | Signed real input sample for the mixer |
| nco_out | output | 18 | Signed oscillator sample |
| nco_is_sin | output | 1 | 0 = cosine sample, 1 = sine sample |
| nco_valid | output | 1 | Oscillator pipeline holds real data |
| bb_out | output | 32 | Signed mixer product (I or Q) |
| bb_is_q | output | 1 | 0 = I product, 1 = Q product |
| bb_valid | output | 1 | Mixer output holds real data |

## Verification
Several properties are checked on every cycle. The slot flag must strictly alternate once data flows, and valid must stay high. The accumulator may move only on cycles that follow a sine slot, and the tuning word may change only after a write strobe. Samples must stay within the amplitude bound, and the mixer tags and zero products must follow the oscillator by one cycle. The numeric side needs the bench scenarios. These cover interpolation accuracy against a real-valued sine and cosine, the exact eight-cycle alignment, and phase continuity when the tuning word changes mid-pair. They also cover the exact value at the 1023-to-0 wrap, the frozen zero-frequency outputs, and the I/Q products that share one ADC sample.

// File: rtl/dds_pkg.sv
package dds_pkg;
    // Slot sequencer states: cosine slot carries the quarter-turn offset
    typedef enum logic {
        SLOT_COS = 1'b0,
        SLOT_SIN = 1'b1
    } slot_e;
endpackage

// File: rtl/dds_delay.sv
module dds_delay #(
    parameter int W = 1,
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [N-1:0][W-1:0] sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr <= '0;
        end else begin
            sr[0] <= d;
            for (int i = 1; i < N; i++) begin
                sr[i] <= sr[i-1];
            end
        end
    end

    assign q = sr[N-1];
endmodule

// File: rtl/dds_phase_gen.sv
module dds_phase_gen
    import dds_pkg::*;
#(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 10,
    parameter int FRAC_W = 18,
    localparam int PH_W  = ADDR_W + FRAC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freq_wr,
    input  logic [ACC_W-1:0] freq_data,
    output logic [PH_W-1:0]  phase_q,
    output logic             phase_is_sin,
    output logic             phase_valid,
    output logic [ACC_W-1:0] acc_val,
    output logic [ACC_W-1:0] freq_val
);
    localparam logic [PH_W-1:0] QUARTER = PH_W'(1) << (PH_W - 2);

    slot_e            slot_q, slot_d;
    logic             step_en;
    logic [PH_W-1:0]  offset;
    logic [ACC_W-1:0] acc_q, freq_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) slot_q <= SLOT_COS;
        else        slot_q <= slot_d;
    end

    // transitions and per-state controls
    always_comb begin
        slot_d  = slot_q;
        step_en = 1'b0;
        offset  = '0;
        unique case (slot_q)
            SLOT_COS: begin
                slot_d = SLOT_SIN;
                offset = QUARTER;
            end
            SLOT_SIN: begin
                slot_d  = SLOT_COS;
                step_en = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q        <= '0;
            freq_q       <= '0;
            phase_q      <= '0;
            phase_is_sin <= 1'b0;
            phase_valid  <= 1'b0;
        end else begin
            if (step_en) acc_q  <= acc_q + freq_q;
            if (freq_wr) freq_q <= freq_data;
            phase_q      <= acc_q[ACC_W-1 -: PH_W] + offset;
            phase_is_sin <= (slot_q == SLOT_SIN);
            phase_valid  <= 1'b1;
        end
    end

    assign acc_val  = acc_q;
    assign freq_val = freq_q;
endmodule

// File: rtl/dds_sine_interp.sv
module dds_sine_interp #(
    parameter int ADDR_W = 10,
    parameter int FRAC_W = 18,
    parameter int LUT_W  = 18,
    localparam int PH_W   = ADDR_W + FRAC_W,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int PROD_W = 2 * (LUT_W + 1),
    localparam int AMP    = (1 << (LUT_W - 1)) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [PH_W-1:0]         phase,
    input  logic                    phase_is_sin,
    input  logic                    phase_valid,
    output logic signed [LUT_W-1:0] sample,
    output logic                    sample_is_sin,
    output logic                    sample_valid
);
    localparam logic signed [PROD_W-1:0] HALF = PROD_W'(1) << (FRAC_W - 1);

    // sine table computed at elaboration
    logic signed [LUT_W-1:0] lut [DEPTH];
    for (genvar i = 0; i < DEPTH; i++) begin : g_lut
        localparam real ANG = 6.283185307179586 * real'(i) / real'(DEPTH);
        localparam int  VAL = $rtoi($floor(real'(AMP) * $sin(ANG) + 0.5));
        assign lut[i] = LUT_W'(VAL);
    end

    logic [ADDR_W-1:0]        idx0_s2, idx1_s2;
    logic [FRAC_W-1:0]        frac_s2, frac_s3, frac_s4;
    logic signed [LUT_W-1:0]  e0_s3, e1_s3, e0_s6;
    logic signed [LUT_W:0]    diff_s4, scaled_s6, sum_s7;
    logic signed [PROD_W-1:0] prod_s5, rnd;
    logic [1:0]               tag_out;

    assign rnd = prod_s5 + HALF;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx0_s2   <= '0;
            idx1_s2   <= '0;
            frac_s2   <= '0;
            frac_s3   <= '0;
            frac_s4   <= '0;
            e0_s3     <= '0;
            e1_s3     <= '0;
            diff_s4   <= '0;
            prod_s5   <= '0;
            scaled_s6 <= '0;
            sum_s7    <= '0;
            sample    <= '0;
        end else begin
            idx0_s2   <= phase[PH_W-1 -: ADDR_W];
            idx1_s2   <= phase[PH_W-1 -: ADDR_W] + ADDR_W'(1);
            frac_s2   <= phase[FRAC_W-1:0];
            e0_s3     <= lut[idx0_s2];
            e1_s3     <= lut[idx1_s2];
            frac_s3   <= frac_s2;
            diff_s4   <= {e1_s3[LUT_W-1], e1_s3} - {e0_s3[LUT_W-1], e0_s3};
            frac_s4   <= frac_s3;
            prod_s5   <= diff_s4 * $signed({1'b0, frac_s4});
            scaled_s6 <= (LUT_W + 1)'(rnd >>> FRAC_W);
            sum_s7    <= {e0_s6[LUT_W-1], e0_s6} + scaled_s6;
            sample    <= sum_s7[LUT_W-1:0];
        end
    end

    // first entry travels alongside diff/product/rounding
    dds_delay #(.W(LUT_W), .N(3)) u_e0_dly (
        .clk(clk), .rst_n(rst_n), .d(e0_s3), .q(e0_s6)
    );

    // slot tag and valid ride the seven stages after the phase register
    dds_delay #(.W(2), .N(7)) u_tag_dly (
        .clk(clk), .rst_n(rst_n), .d({phase_valid, phase_is_sin}), .q(tag_out)
    );

    assign sample_valid  = tag_out[1];
    assign sample_is_sin = tag_out[0];
endmodule

// File: rtl/dds_rx_mixer.sv
module dds_rx_mixer #(
    parameter int ADC_W = 14,
    parameter int LUT_W = 18,
    localparam int MIX_W = ADC_W + LUT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic signed [ADC_W-1:0] adc_data,
    input  logic signed [LUT_W-1:0] nco_val,
    input  logic                    nco_is_sin,
    input  logic                    nco_valid,
    output logic signed [MIX_W-1:0] bb_out,
    output logic                    bb_is_q,
    output logic                    bb_valid
);
    logic signed [ADC_W-1:0] hold_q, adc_use;
    logic signed [MIX_W-1:0] prod;

    assign adc_use = nco_is_sin ? hold_q : adc_data;
    assign prod    = adc_use * nco_val;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_q   <= '0;
            bb_out   <= '0;
            bb_is_q  <= 1'b0;
            bb_valid <= 1'b0;
        end else begin
            if (nco_valid && !nco_is_sin) hold_q <= adc_data;
            bb_out   <= prod;
            bb_is_q  <= nco_is_sin;
            bb_valid <= nco_valid;
        end
    end
endmodule

// File: rtl/dds_iq_nco.sv
module dds_iq_nco #(
    parameter int ACC_W  = 32,
    parameter int ADDR_W = 10,
    parameter int FRAC_W = 18,
    parameter int LUT_W  = 18,
    parameter int ADC_W  = 14,
    localparam int PH_W  = ADDR_W + FRAC_W,
    localparam int MIX_W = ADC_W + LUT_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    freq_wr,
    input  logic [ACC_W-1:0]        freq_data,
    input  logic signed [ADC_W-1:0] adc_data,
    output logic signed [LUT_W-1:0] nco_out,
    output logic                    nco_is_sin,
    output logic                    nco_valid,
    output logic signed [MIX_W-1:0] bb_out,
    output logic                    bb_is_q,
    output logic                    bb_valid
);
    logic [PH_W-1:0]  phase;
    logic             phase_is_sin, phase_valid;
    logic [ACC_W-1:0] acc_val, freq_val;

    dds_phase_gen #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .FRAC_W(FRAC_W)) u_phase (
        .clk          (clk),
        .rst_n        (rst_n),
        .freq_wr      (freq_wr),
        .freq_data    (freq_data),
        .phase_q      (phase),
        .phase_is_sin (phase_is_sin),
        .phase_valid  (phase_valid),
        .acc_val      (acc_val),
        .freq_val     (freq_val)
    );

    dds_sine_interp #(.ADDR_W(ADDR_W), .FRAC_W(FRAC_W), .LUT_W(LUT_W)) u_interp (
        .clk           (clk),
        .rst_n         (rst_n),
        .phase         (phase),
        .phase_is_sin  (phase_is_sin),
        .phase_valid   (phase_valid),
        .sample        (nco_out),
        .sample_is_sin (nco_is_sin),
        .sample_valid  (nco_valid)
    );

    dds_rx_mixer #(.ADC_W(ADC_W), .LUT_W(LUT_W)) u_mix (
        .clk        (clk),
        .rst_n      (rst_n),
        .adc_data   (adc_data),
        .nco_val    (nco_out),
        .nco_is_sin (nco_is_sin),
        .nco_valid  (nco_valid),
        .bb_out     (bb_out),
        .bb_is_q    (bb_is_q),
        .bb_valid   (bb_valid)
    );
endmodule

// File: rtl/dds_iq_nco_chk.sv
module dds_iq_nco_chk #(
    parameter int ACC_W = 32,
    parameter int LUT_W = 18,
    parameter int MIX_W = 32
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    freq_wr,
    input logic [ACC_W-1:0]        acc_val,
    input logic [ACC_W-1:0]        freq_val,
    input logic                    phase_is_sin,
    input logic signed [LUT_W-1:0] nco_out,
    input logic                    nco_is_sin,
    input logic                    nco_valid,
    input logic signed [MIX_W-1:0] bb_out,
    input logic                    bb_is_q,
    input logic                    bb_valid
);
    localparam logic signed [LUT_W-1:0] AMP = LUT_W'((1 << (LUT_W - 1)) - 1);

    // R1
    valid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nco_valid |=> nco_valid);

    // R2
    flag_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nco_valid && $past(nco_valid)) |-> (nco_is_sin != $past(nco_is_sin)));

    // R3
    acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_is_sin |-> $stable(acc_val));

    // R5
    freq_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !freq_wr |=> $stable(freq_val));

    // R4
    amp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nco_out <= AMP) && (nco_out >= -AMP));

    // R8
    bb_tag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nco_valid |=> (bb_valid && (bb_is_q == $past(nco_is_sin))));

    // R8
    bb_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nco_valid && (nco_out == '0)) |=> (bb_out == '0));
endmodule

bind dds_iq_nco dds_iq_nco_chk #(.ACC_W(ACC_W), .LUT_W(LUT_W), .MIX_W(MIX_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .freq_wr      (freq_wr),
    .acc_val      (acc_val),
    .freq_val     (freq_val),
    .phase_is_sin (phase_is_sin),
    .nco_out      (nco_out),
    .nco_is_sin   (nco_is_sin),
    .nco_valid    (nco_valid),
    .bb_out       (bb_out),
    .bb_is_q      (bb_is_q),
    .bb_valid     (bb_valid)
);

// File: tb/dds_iq_nco_tb.sv
`timescale 1ns/1ps
module dds_iq_nco_tb;
    localparam int  ADC_W = 14;
    localparam int  LUT_W = 18;
    localparam int  MIX_W = 32;
    localparam int  LAT   = 8;
    localparam real AMPR  = 131071.0;
    localparam int  NVEC  = 6;
    localparam logic [31:0] VEC_FREQ [NVEC] = '{32'h0100_0000, 32'h0123_4567, 32'hFFE0_0000,
                                                32'h8000_0000, 32'h7FFF_FFF0, 32'h0000_0000};
    localparam int VEC_CYC [NVEC] = '{700, 600, 500, 200, 300, 100};

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    freq_wr = 1'b0;
    logic [31:0]             freq_data = '0;
    logic signed [ADC_W-1:0] adc_data = '0;
    logic signed [LUT_W-1:0] nco_out;
    logic                    nco_is_sin, nco_valid;
    logic signed [MIX_W-1:0] bb_out;
    logic                    bb_is_q, bb_valid;

    dds_iq_nco u_dut (
        .clk(clk), .rst_n(rst_n), .freq_wr(freq_wr), .freq_data(freq_data),
        .adc_data(adc_data), .nco_out(nco_out), .nco_is_sin(nco_is_sin),
        .nco_valid(nco_valid), .bb_out(bb_out), .bb_is_q(bb_is_q), .bb_valid(bb_valid)
    );

    always #2.5 clk = ~clk;

    int total = 0;
    int bad = 0;
    int k;
    int adc_seed = 12345;
    logic ms;
    logic [31:0] ma, mf, pend_d;
    logic pend_wr;
    logic hs [16];
    logic [31:0] ha [16];
    logic bbe_v, bbe_q;
    logic signed [MIX_W-1:0] bbe;
    logic signed [ADC_W-1:0] m_hold;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic real ideal(input logic s, input logic [31:0] a);
        logic [31:0] p;
        p = s ? a : a + 32'h4000_0000;
        return AMPR * $sin(6.283185307179586 * real'(p) / 4294967296.0);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        freq_wr = 1'b0;
        adc_data = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(nco_out == 0, "R1", "nco_out in reset", nco_out, 0);
        chk(nco_valid == 0, "R1", "nco_valid in reset", nco_valid, 0);
        chk(bb_out == 0, "R1", "bb_out in reset", bb_out, 0);
        chk(bb_valid == 0, "R1", "bb_valid in reset", bb_valid, 0);
        rst_n = 1'b1;
        k = 0; ms = 1'b0; ma = '0; mf = '0;
        pend_wr = 1'b0; pend_d = '0;
        hs[0] = 1'b0; ha[0] = '0;
        bbe_v = 1'b0; bbe_q = 1'b0; bbe = '0; m_hold = '0;
    endtask

    task automatic cycle(input logic wr, input logic [31:0] wd, input string tag);
        int idx;
        real e, d;
        logic signed [ADC_W-1:0] new_adc, use_adc;
        @(negedge clk);
        k++;
        if (ms) ma = ma + mf;
        ms = ~ms;
        if (pend_wr) mf = pend_d;
        hs[k % 16] = ms;
        ha[k % 16] = ma;
        if (k < LAT) begin
            chk(nco_valid == 0, "R7", "valid before latency", nco_valid, 0);
        end else begin
            idx = (k - LAT) % 16;
            chk(nco_valid == 1, "R7", "valid after latency", nco_valid, 1);
            chk(nco_is_sin == hs[idx], "R2", "slot flag", nco_is_sin, hs[idx]);
            e = ideal(hs[idx], ha[idx]);
            d = real'(nco_out) - e;
            if (d < 0.0) d = -d;
            chk(d <= 2.0, tag, "sample value", nco_out, $rtoi(e));
        end
        chk(bb_valid == bbe_v, "R8", "bb_valid", bb_valid, bbe_v);
        if (bbe_v) begin
            chk(bb_is_q == bbe_q, "R8", "bb_is_q", bb_is_q, bbe_q);
            chk(bb_out == bbe, "R8", "bb product", bb_out, bbe);
        end
        adc_seed = adc_seed * 1103515245 + 12345;
        new_adc  = adc_seed[27:14];
        use_adc  = nco_is_sin ? m_hold : new_adc;
        bbe      = MIX_W'(longint'(use_adc) * longint'(nco_out));
        bbe_v    = nco_valid;
        bbe_q    = nco_is_sin;
        if (nco_valid && !nco_is_sin) m_hold = new_adc;
        adc_data  = new_adc;
        freq_wr   = wr;
        freq_data = wd;
        pend_wr   = wr;
        pend_d    = wd;
    endtask

    initial begin
        // R9: zero tuning word after reset
        do_reset();
        for (int c = 0; c < 24; c++) begin
            cycle(1'b0, 32'h0, "R4");
            if (k >= LAT) begin
                if (nco_is_sin) chk(nco_out == 0, "R9", "sine at zero phase", nco_out, 0);
                else chk(nco_out == 131071, "R9", "cosine at zero phase", nco_out, 131071);
            end
        end

        // vector table: tuning words applied mid-run, phase carried over (R3, R5)
        for (int v = 0; v < NVEC; v++) begin
            cycle(1'b1, VEC_FREQ[v], "R5");
            for (int c = 1; c < VEC_CYC[v]; c++) begin
                cycle(1'b0, 32'h0, (c < 24) ? "R5" : "R4");
            end
        end

        // R6: wrap at table index 1023, reset mid-run also rechecks R1
        do_reset();
        cycle(1'b1, 32'hFFE0_0000, "R6");
        cycle(1'b0, 32'h0, "R6");
        cycle(1'b1, 32'h0, "R6");
        for (int c = 0; c < 30; c++) begin
            cycle(1'b0, 32'h0, "R6");
            if (k >= 14 && nco_is_sin)
                chk(nco_out == -402, "R6", "sine at index 1023 half step", nco_out, -402);
        end

        // R3: odd tuning word over a long stretch
        cycle(1'b1, 32'h0357_9BDF, "R3");
        for (int c = 0; c < 400; c++) cycle(1'b0, 32'h0, "R3");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #750000;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule